// File: doc/BRIEF.md
# Parameterized Arithmetic-Logic Unit with Status Flags

This block is the combinational arithmetic-logic unit of a small accumulator-style processor whose data width `W` is a parameter: any even number of at least 8 bits. Each evaluation takes a first operand `a_i` and a second operand `b_i`. In a processor, `a_i` comes from the accumulator and `b_i` from a dedicated operand register. The block also takes the current carry and overflow bits of the status register and a 4-bit operation code. It returns a `W`-bit result, which the surrounding datapath writes back into the accumulator. It also returns the next values of the carry, overflow, zero and negative flags.

The block supports eleven operations:

- add with carry, subtract, increment and decrement;
- bitwise OR, AND, XOR and one's complement;
- a rotate left and a rotate right, both through the carry;
- a transfer that copies the second operand.

A flag that an operation does not define passes its incoming value straight through. The status register can therefore latch all four flags after every operation. The block holds no state: registering the result, latching the flags and sequencing operations happen outside it.

Top module: `alu_core`

## Requirements
- R1: With `op_i`=0 (add), `y_o` = (a + b + c_i) mod 2^W. `c_o` is the carry out of bit W-1. `v_o` is set when the signed two's-complement sum of a, b and c_i falls outside the W-bit signed range.
- R2: With `op_i`=1 (subtract), `y_o` = (a - b) mod 2^W and `c_i` is ignored. `c_o` is 1 exactly when a >= b as unsigned numbers. `v_o` flags signed overflow of a - b.
- R3: With `op_i`=2 (increment) `y_o` = a+1 mod 2^W. With `op_i`=3 (decrement) `y_o` = a-1 mod 2^W. Both copy `c_i` to `c_o` and set `v_o` on signed overflow.
- R4: Codes 4, 5, 6 and 7 give a OR b, a AND b, NOT a and a XOR b, in that order. They copy `c_i` to `c_o` and `v_i` to `v_o`.
- R5: With `op_i`=8 (rotate left through carry), `y_o` = {a[W-2:0], c_i} and `c_o` = a[W-1]. `v_o` = `v_i`.
- R6: With `op_i`=9 (rotate right through carry), `y_o` = {c_i, a[W-1:1]} and `c_o` = a[0]. `v_o` = `v_i`.
- R7: With `op_i`=10 (transfer) and with every unused code from 11 to 15, `y_o` = b. `c_o` = `c_i` and `v_o` = `v_i`.
- R8: For every operation, `z_o` is 1 exactly when all W bits of `y_o` are 0.
- R9: For every operation, `n_o` equals bit W-1 of `y_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | First operand (accumulator) |
| b_i | input | W | Second operand |
| op_i | input | 4 | Operation code |
| c_i | input | 1 | Current carry flag |
| v_i | input | 1 | Current overflow flag |
| y_o | output | W | Result |
| c_o | output | 1 | Next carry flag |
| v_o | output | 1 | Next overflow flag |
| z_o | output | 1 | Next zero flag |
| n_o | output | 1 | Next negative flag |

## Verification
The immediate assertions in the top module assume that every input is a settled two-state value when the combinational block evaluates. They also assume that an operation code outside 0 to 10 is legal input and must behave as a transfer. The stimulus meets both assumptions:

- The bench changes inputs only just after a rising clock edge and compares at the following falling edge.
- It sweeps all sixteen codes.
- It mixes directed corner operands with pseudo-random ones. The corners are 0, all ones, the signed maximum and minimum, and equal operands for subtraction.

// File: rtl/alu_core_pkg.sv
package alu_core_pkg;

    typedef enum logic [3:0] {
        OP_ADC  = 4'd0,
        OP_SUB  = 4'd1,
        OP_INC  = 4'd2,
        OP_DEC  = 4'd3,
        OP_OR   = 4'd4,
        OP_AND  = 4'd5,
        OP_NOT  = 4'd6,
        OP_XOR  = 4'd7,
        OP_ROL  = 4'd8,
        OP_ROR  = 4'd9,
        OP_PASS = 4'd10
    } alu_op_e;

    typedef enum logic [1:0] {
        CLS_ARITH,
        CLS_LOGIC,
        CLS_SHIFT,
        CLS_PASS
    } alu_cls_e;

    typedef struct packed {
        logic c;
        logic v;
        logic z;
        logic n;
    } alu_flags_t;

    function automatic alu_cls_e op_class(input logic [3:0] code);
        if (code <= 4'd3)       return CLS_ARITH;
        else if (code <= 4'd7)  return CLS_LOGIC;
        else if (code <= 4'd9)  return CLS_SHIFT;
        else                    return CLS_PASS;
    endfunction

endpackage

// File: rtl/alu_adder.sv
module alu_adder
    import alu_core_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [3:0]   op_i,
    input  logic         c_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);
    localparam int WX = W + 1;

    logic [W-1:0]  addend;
    logic          cin_eff;
    logic [WX-1:0] total;

    always_comb begin
        case (op_i)
            OP_SUB: begin addend = ~b_i;          cin_eff = 1'b1; end
            OP_INC: begin addend = '0;            cin_eff = 1'b1; end
            OP_DEC: begin addend = {W{1'b1}};     cin_eff = 1'b0; end
            default: begin addend = b_i;          cin_eff = c_i;  end
        endcase
        total  = {1'b0, a_i} + {1'b0, addend} + {{W{1'b0}}, cin_eff};
        sum_o  = total[W-1:0];
        cout_o = total[W];
        ovf_o  = (a_i[W-1] == addend[W-1]) && (total[W-1] != a_i[W-1]);
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_core_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [3:0]   op_i,
    output logic [W-1:0] y_o
);
    logic [W-1:0] t_or, t_and, t_not, t_xor;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign t_or[i]  = a_i[i] | b_i[i];
        assign t_and[i] = a_i[i] & b_i[i];
        assign t_not[i] = ~a_i[i];
        assign t_xor[i] = a_i[i] ^ b_i[i];
    end

    always_comb begin
        case (op_i)
            OP_OR:   y_o = t_or;
            OP_AND:  y_o = t_and;
            OP_NOT:  y_o = t_not;
            default: y_o = t_xor;
        endcase
    end
endmodule

// File: rtl/alu_rotator.sv
module alu_rotator
    import alu_core_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [3:0]   op_i,
    input  logic         c_i,
    output logic [W-1:0] y_o,
    output logic         cout_o
);
    logic [W-1:0] left_v, right_v;

    assign left_v  = {a_i[W-2:0], c_i};
    assign right_v = {c_i, a_i[W-1:1]};

    always_comb begin
        if (op_i == OP_ROR) begin
            y_o    = right_v;
            cout_o = a_i[0];
        end else begin
            y_o    = left_v;
            cout_o = a_i[W-1];
        end
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_core_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [3:0]   op_i,
    input  logic         c_i,
    input  logic         v_i,
    output logic [W-1:0] y_o,
    output logic         c_o,
    output logic         v_o,
    output logic         z_o,
    output logic         n_o
);
    localparam int MSB = W - 1;

    logic [W-1:0] add_y, log_y, rot_y;
    logic         add_c, add_v, rot_c;
    alu_cls_e     cls;
    alu_flags_t   nxt;
    logic [W-1:0] res;

    alu_adder #(.W(W)) u_add (
        .a_i(a_i), .b_i(b_i), .op_i(op_i), .c_i(c_i),
        .sum_o(add_y), .cout_o(add_c), .ovf_o(add_v)
    );

    alu_logic #(.W(W)) u_log (
        .a_i(a_i), .b_i(b_i), .op_i(op_i), .y_o(log_y)
    );

    alu_rotator #(.W(W)) u_rot (
        .a_i(a_i), .op_i(op_i), .c_i(c_i), .y_o(rot_y), .cout_o(rot_c)
    );

    always_comb begin
        cls   = op_class(op_i);
        nxt.c = c_i;
        nxt.v = v_i;
        case (cls)
            CLS_ARITH: begin
                res   = add_y;
                nxt.v = add_v;
                if (op_i == OP_ADC || op_i == OP_SUB) nxt.c = add_c;
            end
            CLS_LOGIC: res = log_y;
            CLS_SHIFT: begin
                res   = rot_y;
                nxt.c = rot_c;
            end
            default:   res = b_i;
        endcase
        nxt.z = (res == '0);
        nxt.n = res[MSB];
    end

    assign y_o = res;
    assign c_o = nxt.c;
    assign v_o = nxt.v;
    assign z_o = nxt.z;
    assign n_o = nxt.n;

    always_comb begin
        if (op_i == OP_ROL) begin
            p_rol_carry_r5: assert (y_o[0] == c_i && c_o == a_i[MSB] && v_o == v_i)
                else $error("rotate left carry path broken");
        end
        if (op_i == OP_ROR) begin
            p_ror_carry_r6: assert (y_o[MSB] == c_i && c_o == a_i[0] && v_o == v_i)
                else $error("rotate right carry path broken");
        end
        if (op_i >= 4'd10) begin
            p_pass_flags_r7: assert (y_o == b_i && c_o == c_i && v_o == v_i)
                else $error("transfer altered state");
        end
        if (op_i == OP_INC || op_i == OP_DEC) begin
            p_step_keeps_c_r3: assert (c_o == c_i)
                else $error("increment or decrement touched carry");
        end
        if (op_i == OP_SUB) begin
            p_sub_noborrow_r2: assert (c_o == (a_i >= b_i))
                else $error("subtract carry is not no-borrow");
        end
        if (op_i == OP_XOR) begin
            p_xor_inverse_r4: assert ((y_o ^ b_i) == a_i && c_o == c_i && v_o == v_i)
                else $error("xor result not invertible");
        end
        if (op_i == OP_ADC && a_i == '0 && b_i == '0) begin
            p_add_zero_r8: assert (z_o == !c_i)
                else $error("zero flag wrong on empty sum");
        end
    end
endmodule

// File: tb/alu_core_test.sv
module alu_core_test;
    localparam int W    = 8;
    localparam int FULL = 1 << W;
    localparam int HALF = 1 << (W - 1);

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [W-1:0] a, b, y;
    logic [3:0]   op;
    logic         ci, vi, co, vo, zo, no;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    alu_core #(.W(W)) uut (
        .a_i(a), .b_i(b), .op_i(op), .c_i(ci), .v_i(vi),
        .y_o(y), .c_o(co), .v_o(vo), .z_o(zo), .n_o(no)
    );

    function automatic int sg(input int x);
        return (x >= HALF) ? x - FULL : x;
    endfunction

    function automatic bit outside(input int s);
        return (s >= HALF) || (s < -HALF);
    endfunction

    function automatic string tag(input int code);
        case (code)
            0: return "R1";
            1: return "R2";
            2, 3: return "R3";
            4, 5, 6, 7: return "R4";
            8: return "R5";
            9: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic apply(input int ta, input int tb, input int top, input bit tc, input bit tv);
        int er, ec, ev, ez, en;
        bit bad;
        @(posedge clk);
        #0.5;
        a = ta[W-1:0]; b = tb[W-1:0]; op = top[3:0]; ci = tc; vi = tv;
        ec = tc; ev = tv;
        case (top)
            0: begin er = (ta + tb + tc) % FULL; ec = (ta + tb + tc) / FULL;
                     ev = outside(sg(ta) + sg(tb) + tc); end
            1: begin er = (ta - tb + FULL) % FULL; ec = (ta >= tb);
                     ev = outside(sg(ta) - sg(tb)); end
            2: begin er = (ta + 1) % FULL; ev = outside(sg(ta) + 1); end
            3: begin er = (ta + FULL - 1) % FULL; ev = outside(sg(ta) - 1); end
            4: er = ta | tb;
            5: er = ta & tb;
            6: er = (FULL - 1) - ta;
            7: er = ta ^ tb;
            8: begin er = ((ta * 2) % FULL) + tc; ec = ta / HALF; end
            9: begin er = (ta / 2) + tc * HALF; ec = ta % 2; end
            default: er = tb;
        endcase
        ez = (er == 0);
        en = er / HALF;
        @(negedge clk);
        vectors++;
        bad = 1'b0;
        if (int'(y) != er) begin
            bad = 1'b1;
            $display("FAIL %s op=%0d result actual=%0h expected=%0h", tag(top), top, y, er);
        end
        if (int'(co) != ec || int'(vo) != ev) begin
            bad = 1'b1;
            $display("FAIL %s op=%0d carry/ovf actual=%0b%0b expected=%0b%0b",
                     tag(top), top, co, vo, ec[0], ev[0]);
        end
        if (int'(zo) != ez) begin
            bad = 1'b1;
            $display("FAIL R8 op=%0d zero actual=%0b expected=%0b", top, zo, ez[0]);
        end
        if (int'(no) != en) begin
            bad = 1'b1;
            $display("FAIL R9 op=%0d negative actual=%0b expected=%0b", top, no, en[0]);
        end
        if (bad) misses++;
    endtask

    initial begin
        int corner [6] = '{0, 1, HALF - 1, HALF, FULL - 1, 8'h5A};
        a = '0; b = '0; op = '0; ci = 1'b0; vi = 1'b0;
        // quiet state: all-zero inputs give zero result, Z set (R1, R8)
        apply(0, 0, 0, 1'b0, 1'b0);
        // every code over corner operands and both flag inputs (R1..R7, R8, R9)
        for (int o = 0; o < 16; o++)
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++)
                    for (int f = 0; f < 4; f++)
                        apply(corner[i], corner[j], o, f[0], f[1]);
        // R2: equal operands give no borrow and zero
        apply(8'h33, 8'h33, 1, 1'b0, 1'b1);
        // R5 / R6: rotate a single bit across the carry in both directions
        apply(HALF, 0, 8, 1'b0, 1'b0);
        apply(1, 0, 9, 1'b0, 1'b0);
        // pseudo-random sweep
        for (int k = 0; k < 3000; k++)
            apply(int'($urandom % FULL), int'($urandom % FULL),
                  int'($urandom % 16), bit'($urandom % 2), bit'($urandom % 2));
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            misses++;
            $display("FAIL watchdog expired after %0d vectors", vectors);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule